// File: doc/BRIEF.md
# Data-Block Cadence Sequencer

This block decides, once per isochronous bus cycle, how many audio data blocks the packet for that cycle carries. A start pulse arms the block and captures the sample-rate code and the transfer mode. Each advance strobe then yields one registered count, with a one-cycle valid flag. The fractional-rate phase is kept inside the block, so that over a full phase period the block total matches the sample rate divided by 8000 cycles per second exactly.

There are two transfer modes. In non-blocking mode, rates that are a whole multiple of 8000 give a constant count. The 44.1 kHz family follows a fixed phase pattern that puts the rounded-up packets as early in the sequence as possible. In blocking mode every packet carries a fixed interval of blocks, or carries none when the timestamp generator flags the cycle as having no timestamp.

Top module: `blkc_top`

## Requirements
- R1: During and after synchronous reset, `count_o` is 0 and `count_vld_o` is 0 until a strobe is served.
- R2: While armed, an `adv_i` strobe gives `count_vld_o` high on the next cycle only. A strobe before the first `start_i` produces no valid flag.
- R3: Rate codes on `rate_i`: 0=32 kHz, 1=44.1 kHz, 2=48 kHz, 3=88.2 kHz, 4=96 kHz, 5=176.4 kHz, 6=192 kHz. In non-blocking mode (`blocking_i`=0), codes 0/2/4/6 give a constant 4/6/12/24.
- R4: In non-blocking mode at code 1, with phase p (0 to 79, wrapping after 79), the count is 5 + ((p mod 2) XOR (p==0 or p>=40)). This gives 6 6 5 6 5 ...
- R5: In non-blocking mode at code 3, the count is 11 plus 1 when p==0, with the phase wrapping after 39. At code 5, the count is 22 plus 1 when p==0, with the phase wrapping after 19.
- R6: Over any 80 consecutive strobes from a start, the summed counts equal rate×80/8000. At code 1 this is 441.
- R7: In blocking mode (`blocking_i`=1), the count is 8 for codes 0–2, 16 for codes 3–4 and 32 for codes 5–6. It is 0 whenever `no_ts_i` is high on the strobe.
- R8: `start_i` returns the phase to 0. An `adv_i` in the same cycle as `start_i` is ignored, and the phase advances only on served strobes.
- R9: Changes on `rate_i` and `blocking_i` have no effect until the next `start_i`.
- R10: Code 7 gives a count of 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms the block, captures the settings and clears the phase |
| adv_i | input | 1 | One strobe per bus cycle |
| rate_i | input | 3 | Sample-rate code |
| blocking_i | input | 1 | 1 = blocking mode, 0 = non-blocking mode |
| no_ts_i | input | 1 | The cycle carries no timestamp |
| count_o | output | COUNT_W | Data blocks for the served cycle |
| count_vld_o | output | 1 | One-cycle flag that a new count is present |

## Verification
The bench builds the block with its default parameters: a 6-bit count and a 7-bit phase covering the 80-step span. These defaults are small enough to sweep every rate code in both modes over two full phase periods. The expected counts come from the ceiling of the running block total, rate×n/8000. That model is an arithmetic statement of the early-rounding rule, not a copy of the phase pattern, and it makes the per-period totals, the restart of the phase and the deferred settings all directly observable.

// File: rtl/blkc_pkg.sv
package blkc_pkg;

  typedef enum logic [2:0] {
    RATE_32K   = 3'd0,
    RATE_44K1  = 3'd1,
    RATE_48K   = 3'd2,
    RATE_88K2  = 3'd3,
    RATE_96K   = 3'd4,
    RATE_176K4 = 3'd5,
    RATE_192K  = 3'd6,
    RATE_BAD   = 3'd7
  } rate_e;

  // Longest fractional phase period (44.1 kHz family base rate)
  localparam int PHASE_SPAN = 80;

  // Steps in the phase period for a rate; integer rates never leave 0
  function automatic int phase_period(rate_e r);
    case (r)
      RATE_44K1:  return PHASE_SPAN;
      RATE_88K2:  return PHASE_SPAN / 2;
      RATE_176K4: return PHASE_SPAN / 4;
      default:    return 1;
    endcase
  endfunction

  // Blocks per packet in blocking mode
  function automatic int block_interval(rate_e r);
    case (r)
      RATE_32K, RATE_44K1, RATE_48K: return 8;
      RATE_88K2, RATE_96K:           return 16;
      RATE_176K4, RATE_192K:         return 32;
      default:                       return 0;
    endcase
  endfunction

endpackage

// File: rtl/blkc_phase.sv
module blkc_phase #(
  parameter int PHASE_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               step_i,
  input  blkc_pkg::rate_e    rate_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] last_w;
  logic [PHASE_W-1:0] phase_q;

  assign last_w = PHASE_W'(blkc_pkg::phase_period(rate_i) - 1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      phase_q <= '0;
    end else if (step_i) begin
      if (phase_q >= last_w) phase_q <= '0;
      else                   phase_q <= phase_q + PHASE_W'(1);
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/blkc_decode.sv
module blkc_decode #(
  parameter int COUNT_W = 6,
  parameter int PHASE_W = 7
) (
  input  blkc_pkg::rate_e    rate_i,
  input  logic               blk_i,
  input  logic               no_ts_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [COUNT_W-1:0] cnt_o
);
  import blkc_pkg::*;

  localparam logic [PHASE_W-1:0] HALF_SPAN = PHASE_W'(PHASE_SPAN / 2);

  logic first_w;
  logic lift_w;

  assign first_w = (phase_i == '0);
  // odd phases round up in the first half, even phases in the second half
  assign lift_w  = phase_i[0] ^ (first_w || (phase_i >= HALF_SPAN));

  always_comb begin
    if (blk_i) begin
      cnt_o = no_ts_i ? '0 : COUNT_W'(block_interval(rate_i));
    end else begin
      case (rate_i)
        RATE_32K:   cnt_o = COUNT_W'(4);
        RATE_48K:   cnt_o = COUNT_W'(6);
        RATE_96K:   cnt_o = COUNT_W'(12);
        RATE_192K:  cnt_o = COUNT_W'(24);
        RATE_44K1:  cnt_o = COUNT_W'(5) + COUNT_W'(lift_w);
        RATE_88K2:  cnt_o = COUNT_W'(11) + COUNT_W'(first_w);
        RATE_176K4: cnt_o = COUNT_W'(22) + COUNT_W'(first_w);
        default:    cnt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/blkc_top.sv
module blkc_top #(
  parameter int COUNT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               adv_i,
  input  logic [2:0]         rate_i,
  input  logic               blocking_i,
  input  logic               no_ts_i,
  output logic [COUNT_W-1:0] count_o,
  output logic               count_vld_o
);
  import blkc_pkg::*;

  localparam int PHASE_W = $clog2(PHASE_SPAN);

  rate_e              cfg_rate_q;
  logic               cfg_blk_q;
  logic               run_q;
  logic               serve_w;
  logic [PHASE_W-1:0] phase_w;
  logic [COUNT_W-1:0] dec_cnt_w;
  logic [COUNT_W-1:0] cnt_q;
  logic               vld_q;

  assign serve_w = adv_i && run_q && !start_i;

  blkc_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (start_i),
    .step_i  (serve_w),
    .rate_i  (cfg_rate_q),
    .phase_o (phase_w)
  );

  blkc_decode #(.COUNT_W(COUNT_W), .PHASE_W(PHASE_W)) u_decode (
    .rate_i  (cfg_rate_q),
    .blk_i   (cfg_blk_q),
    .no_ts_i (no_ts_i),
    .phase_i (phase_w),
    .cnt_o   (dec_cnt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rate_q <= RATE_32K;
      cfg_blk_q  <= 1'b0;
      run_q      <= 1'b0;
      cnt_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start_i) begin
        cfg_rate_q <= rate_e'(rate_i);
        cfg_blk_q  <= blocking_i;
        run_q      <= 1'b1;
      end else if (serve_w) begin
        cnt_q <= dec_cnt_w;
        vld_q <= 1'b1;
      end
    end
  end

  assign count_o     = cnt_q;
  assign count_vld_o = vld_q;
endmodule

// File: rtl/blkc_checker.sv
module blkc_checker #(
  parameter int COUNT_W = 6,
  parameter int PHASE_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               adv_i,
  input logic               no_ts_i,
  input logic [COUNT_W-1:0] count_o,
  input logic               count_vld_o,
  input logic               blk_q,
  input logic [2:0]         rate_q,
  input logic [PHASE_W-1:0] phase_q
);
  AST_VLD_NEEDS_ADV: assert property (@(posedge clk) disable iff (rst)
    count_vld_o |-> $past(adv_i) && !$past(start_i)); // R2

  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    start_i |=> phase_q == '0); // R8

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(blk_q) && $stable(rate_q)); // R9

  AST_BLK_NO_TS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (count_vld_o && $past(blk_q) && $past(no_ts_i)) |-> count_o == '0); // R7

  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (rst)
    count_vld_o |-> count_o <= COUNT_W'(32)); // R7

  AST_44K1_RANGE: assert property (@(posedge clk) disable iff (rst)
    (count_vld_o && !$past(blk_q) && $past(rate_q) == 3'd1)
      |-> (count_o == COUNT_W'(5) || count_o == COUNT_W'(6))); // R4

  AST_BAD_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (count_vld_o && $past(rate_q) == 3'd7) |-> count_o == '0); // R10
endmodule

bind blkc_top blkc_checker #(.COUNT_W(COUNT_W), .PHASE_W(PHASE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .adv_i       (adv_i),
  .no_ts_i     (no_ts_i),
  .count_o     (count_o),
  .count_vld_o (count_vld_o),
  .blk_q       (cfg_blk_q),
  .rate_q      (cfg_rate_q),
  .phase_q     (phase_w)
);

// File: tb/blkc_top_test.sv
module blkc_top_test;
  localparam int COUNT_W = 6;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_i = 1'b0;
  logic               adv_i = 1'b0;
  logic [2:0]         rate_i = 3'd0;
  logic               blocking_i = 1'b0;
  logic               no_ts_i = 1'b0;
  logic [COUNT_W-1:0] count_o;
  logic               count_vld_o;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  blkc_top #(.COUNT_W(COUNT_W)) uut (
    .clk (clk), .rst (rst), .start_i (start_i), .adv_i (adv_i),
    .rate_i (rate_i), .blocking_i (blocking_i), .no_ts_i (no_ts_i),
    .count_o (count_o), .count_vld_o (count_vld_o)
  );

  function automatic int hz(int code);
    case (code)
      0: return 32000;  1: return 44100;  2: return 48000;
      3: return 88200;  4: return 96000;  5: return 176400;
      6: return 192000; default: return 0;
    endcase
  endfunction

  // early rounding: ceiling of the running total, differenced
  function automatic int exp_nb(int code, int n);
    int k;
    k = n % 80;
    return (hz(code) * (k + 1) + 7999) / 8000 - (hz(code) * k + 7999) / 8000;
  endfunction

  function automatic int exp_blk(int code, bit nots);
    if (nots || code == 7) return 0;
    if (hz(code) >= 176400) return 32;
    if (hz(code) >= 88200) return 16;
    return 8;
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(int code, bit blk);
    @(negedge clk);
    rate_i = 3'(code); blocking_i = blk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one strobe; outputs are sampled one negedge later
  task automatic strobe(bit nots);
    @(negedge clk);
    adv_i = 1'b1; no_ts_i = nots;
    @(negedge clk);
    adv_i = 1'b0; no_ts_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", int'(count_o), 0);
    chk("R1 vld in reset", int'(count_vld_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 vld after reset", int'(count_vld_o), 0);

    // R2: strobe before any start is not served
    strobe(1'b0);
    chk("R2 vld before start", int'(count_vld_o), 0);
    chk("R1 count before start", int'(count_o), 0);

    // R3 R4 R5 R6: non-blocking sweep, every code, two periods, idle gaps
    for (int code = 0; code < 8; code++) begin
      int sum;
      sum = 0;
      do_start(code, 1'b0);
      for (int n = 0; n < 160; n++) begin
        if (n % 7 == 3) @(negedge clk);
        strobe(n[0]);
        chk("R2 vld on strobe", int'(count_vld_o), 1);
        if (code == 7)      chk("R10 bad code nb", int'(count_o), 0);
        else if (code == 1) chk("R4 44.1k pattern", int'(count_o), exp_nb(code, n));
        else if (code == 3 || code == 5)
                            chk("R5 88.2k/176.4k pattern", int'(count_o), exp_nb(code, n));
        else                chk("R3 integer rate", int'(count_o), exp_nb(code, n));
        if (n < 80) sum += int'(count_o);
        @(negedge clk);
        chk("R2 vld single cycle", int'(count_vld_o), 0);
      end
      chk("R6 period total", sum, hz(code) * 80 / 8000);
    end

    // R7 R10: blocking sweep with no-timestamp pattern
    for (int code = 0; code < 8; code++) begin
      do_start(code, 1'b1);
      for (int n = 0; n < 12; n++) begin
        bit nots;
        nots = (n % 3 == 1);
        strobe(nots);
        if (code == 7) chk("R10 bad code blk", int'(count_o), 0);
        else           chk("R7 blocking count", int'(count_o), exp_blk(code, nots));
      end
    end

    // R8: restart mid-sequence clears phase; start+adv together is ignored
    do_start(1, 1'b0);
    for (int n = 0; n < 7; n++) strobe(1'b0);
    chk("R8 pre-restart phase 6", int'(count_o), exp_nb(1, 6));
    @(negedge clk);
    rate_i = 3'd3; start_i = 1'b1; adv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; adv_i = 1'b0;
    chk("R8 start wins over adv", int'(count_vld_o), 0);
    for (int n = 0; n < 3; n++) begin
      strobe(1'b0);
      chk("R8 phase restarts at 0", int'(count_o), exp_nb(3, n));
    end

    // R9: settings changed without start do not apply
    do_start(1, 1'b0);
    for (int n = 0; n < 3; n++) strobe(1'b0);
    @(negedge clk);
    rate_i = 3'd6; blocking_i = 1'b1;
    for (int n = 3; n < 8; n++) begin
      strobe(1'b1);
      chk("R9 old settings kept", int'(count_o), exp_nb(1, n));
    end
    do_start(6, 1'b1);
    strobe(1'b0);
    chk("R9 new settings at start", int'(count_o), 32);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule